// File: doc/BRIEF.md
# Delayed-Branch Next-PC Unit

This block holds the program-counter pair of a 32-bit core with one branch delay slot: the address of the instruction retiring now (`pcOut`) and the address that retires after it (`nextPcOut`). Each cycle in which stepping is enabled and the core is not halted, the pair moves forward by one instruction. The current address takes the old following address. The following address takes either the sequential successor or a control-transfer target. A taken branch or jump therefore never skips its delay slot: the instruction after it always runs first.

The retire stage feeds the decoded opcode, function field, the rt field of a register-immediate branch, the 16-bit branch offset, the 26-bit jump index, the two source operand values and the rd index. Conditional branches compare the operands. Direct jumps build their target inside the 256 MB region of the delay slot. Register jumps go to the rs value. Linking jumps also present a return address and a destination register index, which the register file writes in the same cycle.

Top module: `delay_slot_pc`

## Requirements
- R1: While `rst_n` is low, `pcOut` is parameter `START_ADDR` and `nextPcOut` is `START_ADDR + 4`.
- R2: When the pair advances on an instruction that is not a control transfer, `pcOut` takes the old `nextPcOut` and `nextPcOut` takes the old `nextPcOut + 4`.
- R3: The pair advances only on a clock edge where `stepEn` is 1 and `halted` is 0. Otherwise both registers keep their values and `linkValid` is 0.
- R4: Opcode 4 is taken when `rsVal == rtVal`. Opcode 5 is taken when they differ.
- R5: Opcode 6 is taken when `rsVal` as a signed number is at most 0. Opcode 7 is taken when it is above 0.
- R6: Opcode 1 uses `rtField`: value 0 is taken when signed `rsVal < 0`, value 1 is taken when signed `rsVal >= 0`, and any other value is never taken and advances like R2.
- R7: On any branch or jump, `pcOut` takes the old `nextPcOut`. A taken branch loads `nextPcOut` with `pcOut + 4 + (sign-extended offset16 << 2)`. A branch that is not taken loads old `nextPcOut + 4`.
- R8: Opcodes 2 and 3 load `nextPcOut` with `{old nextPcOut[31:28], jumpIndex, 2'b00}`.
- R9: Opcode 0 with `funct` 8 or 9 loads `nextPcOut` with `rsVal`.
- R10: `linkValid` is 1 in an advancing cycle on opcode 3, with `linkIdx` 31, or on opcode 0 / `funct` 9 with a nonzero `rdIdx`, with `linkIdx = rdIdx`. `linkValue` is `pcOut + 8`. A link index of 0 never gives `linkValid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stepEn | input | 1 | Retire one instruction this cycle |
| halted | input | 1 | Freeze the PC pair |
| opcode | input | 6 | Primary opcode of the retiring instruction |
| funct | input | 6 | Function field (opcode 0) |
| rtField | input | 5 | rt field, selects the register-immediate branch kind |
| rdIdx | input | 5 | rd register index (link target of a register jump) |
| offset16 | input | 16 | Branch offset in words |
| jumpIndex | input | 26 | Direct jump word index |
| rsVal | input | 32 | rs operand value / register jump target |
| rtVal | input | 32 | rt operand value |
| pcOut | output | 32 | Address of the current instruction |
| nextPcOut | output | 32 | Address of the following (delay-slot) instruction |
| linkValid | output | 1 | Write the link value this cycle |
| linkIdx | output | 5 | Destination register of the link |
| linkValue | output | 32 | Return address, skipping the delay slot |

## Verification
The bound assertions check on every cycle that a frozen cycle changes neither register, that every advance moves the old following address into `pcOut`, that sequential instructions add exactly 4, that direct jumps keep the delay slot's top four bits, and that link outputs never name register 0 and always carry `pcOut + 8`. Which branches are taken cannot be seen from a single cycle's structure. The bench's scenarios show it: equal and unequal operands, zero, negative and positive values for the signed tests, the unused register-immediate codes, and backward offsets. Only those scenarios also show the reset values and the difference between a register jump with rd 0 and one with a real link register.

// File: rtl/dspc_pkg.sv
package dspc_pkg;
  localparam int XLEN      = 32;
  localparam int OP_W      = 6;
  localparam int REG_W     = 5;
  localparam int OFF_W     = 16;
  localparam int IDX_W     = 26;
  localparam int INSN_B    = 4;
  localparam int REGION_W  = XLEN - IDX_W - 2;

  localparam logic [OP_W-1:0]  OP_SPECIAL = 6'd0;
  localparam logic [OP_W-1:0]  OP_RIMM    = 6'd1;
  localparam logic [OP_W-1:0]  OP_JDIR    = 6'd2;
  localparam logic [OP_W-1:0]  OP_JDIRL   = 6'd3;
  localparam logic [OP_W-1:0]  OP_BR_EQ   = 6'd4;
  localparam logic [OP_W-1:0]  OP_BR_NE   = 6'd5;
  localparam logic [OP_W-1:0]  OP_BR_LEZ  = 6'd6;
  localparam logic [OP_W-1:0]  OP_BR_GTZ  = 6'd7;
  localparam logic [OP_W-1:0]  FN_JREG    = 6'd8;
  localparam logic [OP_W-1:0]  FN_JREGL   = 6'd9;
  localparam logic [REG_W-1:0] RIMM_LTZ   = 5'd0;
  localparam logic [REG_W-1:0] RIMM_GEZ   = 5'd1;
  localparam logic [REG_W-1:0] RET_REG    = 5'd31;

  typedef enum logic [1:0] {
    TGT_SEQ,
    TGT_BRANCH,
    TGT_JUMP,
    TGT_REG
  } tgtSel_t;

  typedef struct packed {
    logic             advance;
    tgtSel_t          tgtSel;
    logic             linkEn;
    logic [REG_W-1:0] linkIdx;
  } pcStrobes_t;
endpackage

// File: rtl/dspc_ctrl.sv
module dspc_ctrl
  import dspc_pkg::*;
(
  input  logic              stepEn,
  input  logic              halted,
  input  logic [OP_W-1:0]   opcode,
  input  logic [OP_W-1:0]   funct,
  input  logic [REG_W-1:0]  rtField,
  input  logic [REG_W-1:0]  rdIdx,
  input  logic [XLEN-1:0]   rsVal,
  input  logic [XLEN-1:0]   rtVal,
  output pcStrobes_t        strobes
);
  logic             taken;
  logic             rsNeg;
  logic             rsZero;
  logic [REG_W-1:0] wantIdx;
  logic             wantLink;

  assign rsNeg  = rsVal[XLEN-1];
  assign rsZero = (rsVal == '0);

  always_comb begin
    taken = 1'b0;
    unique case (opcode)
      OP_BR_EQ:  taken = (rsVal == rtVal);
      OP_BR_NE:  taken = (rsVal != rtVal);
      OP_BR_LEZ: taken = rsNeg | rsZero;
      OP_BR_GTZ: taken = ~rsNeg & ~rsZero;
      OP_RIMM: begin
        if (rtField == RIMM_LTZ)      taken = rsNeg;
        else if (rtField == RIMM_GEZ) taken = ~rsNeg;
        else                          taken = 1'b0;
      end
      default:   taken = 1'b0;
    endcase
  end

  always_comb begin
    strobes.tgtSel = TGT_SEQ;
    wantLink       = 1'b0;
    wantIdx        = '0;
    if (opcode == OP_JDIR || opcode == OP_JDIRL) begin
      strobes.tgtSel = TGT_JUMP;
      wantLink       = (opcode == OP_JDIRL);
      wantIdx        = RET_REG;
    end else if (opcode == OP_SPECIAL && (funct == FN_JREG || funct == FN_JREGL)) begin
      strobes.tgtSel = TGT_REG;
      wantLink       = (funct == FN_JREGL);
      wantIdx        = rdIdx;
    end else if (taken) begin
      strobes.tgtSel = TGT_BRANCH;
    end
  end

  assign strobes.advance = stepEn & ~halted;
  assign strobes.linkEn  = strobes.advance & wantLink & (wantIdx != '0);
  assign strobes.linkIdx = wantIdx;
endmodule

// File: rtl/dspc_path.sv
module dspc_path
  import dspc_pkg::*;
#(
  parameter logic [XLEN-1:0] START_ADDR = 32'h0000_1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  pcStrobes_t        strobes,
  input  logic [OFF_W-1:0]  offset16,
  input  logic [IDX_W-1:0]  jumpIndex,
  input  logic [XLEN-1:0]   rsVal,
  output logic [XLEN-1:0]   pcQ,
  output logic [XLEN-1:0]   npcQ,
  output logic [XLEN-1:0]   linkValue
);
  localparam logic [XLEN-1:0] STEP = XLEN'(INSN_B);

  logic [XLEN-1:0] seqAddr;
  logic [XLEN-1:0] brOffset;
  logic [XLEN-1:0] brTarget;
  logic [XLEN-1:0] jTarget;
  logic [XLEN-1:0] npcNext;

  assign seqAddr  = npcQ + STEP;
  assign brOffset = {{(XLEN-OFF_W-2){offset16[OFF_W-1]}}, offset16, 2'b00};
  assign brTarget = pcQ + STEP + brOffset;
  assign jTarget  = {npcQ[XLEN-1 -: REGION_W], jumpIndex, 2'b00};
  assign linkValue = pcQ + STEP + STEP;

  always_comb begin
    unique case (strobes.tgtSel)
      TGT_BRANCH: npcNext = brTarget;
      TGT_JUMP:   npcNext = jTarget;
      TGT_REG:    npcNext = rsVal;
      default:    npcNext = seqAddr;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pcQ  <= START_ADDR;
      npcQ <= START_ADDR + STEP;
    end else if (strobes.advance) begin
      pcQ  <= npcQ;
      npcQ <= npcNext;
    end
  end
endmodule

// File: rtl/delay_slot_pc.sv
module delay_slot_pc
  import dspc_pkg::*;
#(
  parameter logic [31:0] START_ADDR = 32'h0000_1000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        stepEn,
  input  logic        halted,
  input  logic [5:0]  opcode,
  input  logic [5:0]  funct,
  input  logic [4:0]  rtField,
  input  logic [4:0]  rdIdx,
  input  logic [15:0] offset16,
  input  logic [25:0] jumpIndex,
  input  logic [31:0] rsVal,
  input  logic [31:0] rtVal,
  output logic [31:0] pcOut,
  output logic [31:0] nextPcOut,
  output logic        linkValid,
  output logic [4:0]  linkIdx,
  output logic [31:0] linkValue
);
  pcStrobes_t strobes;

  dspc_ctrl u_ctrl (
    .stepEn(stepEn), .halted(halted), .opcode(opcode), .funct(funct),
    .rtField(rtField), .rdIdx(rdIdx), .rsVal(rsVal), .rtVal(rtVal),
    .strobes(strobes)
  );

  dspc_path #(.START_ADDR(START_ADDR)) u_path (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .offset16(offset16),
    .jumpIndex(jumpIndex), .rsVal(rsVal), .pcQ(pcOut), .npcQ(nextPcOut),
    .linkValue(linkValue)
  );

  assign linkValid = strobes.linkEn;
  assign linkIdx   = strobes.linkIdx;
endmodule

// File: rtl/delay_slot_pc_chk.sv
module delay_slot_pc_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        stepEn,
  input logic        halted,
  input logic [5:0]  opcode,
  input logic [5:0]  funct,
  input logic [25:0] jumpIndex,
  input logic [31:0] pcOut,
  input logic [31:0] nextPcOut,
  input logic        linkValid,
  input logic [4:0]  linkIdx,
  input logic [31:0] linkValue
);
  logic adv;
  logic isCtl;
  assign adv   = stepEn && !halted;
  assign isCtl = (opcode >= 6'd1 && opcode <= 6'd7) ||
                 (opcode == 6'd0 && (funct == 6'd8 || funct == 6'd9));

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> ($stable(pcOut) && $stable(nextPcOut)));

  assert_nolink_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |-> !linkValid);

  assert_slot_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> (pcOut == $past(nextPcOut)));

  assert_seq_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !isCtl) |=> (nextPcOut == $past(nextPcOut) + 32'd4));

  assert_region_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && (opcode == 6'd2 || opcode == 6'd3)) |=>
      (nextPcOut == {$past(nextPcOut[31:28]), $past(jumpIndex), 2'b00}));

  assert_link_value_R10: assert property (@(posedge clk) disable iff (!rst_n)
    linkValid |-> (linkIdx != 5'd0 && linkValue == pcOut + 32'd8));

  assert_jal_reg_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && opcode == 6'd3) |-> (linkValid && linkIdx == 5'd31));
endmodule

bind delay_slot_pc delay_slot_pc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .stepEn(stepEn), .halted(halted),
  .opcode(opcode), .funct(funct), .jumpIndex(jumpIndex),
  .pcOut(pcOut), .nextPcOut(nextPcOut), .linkValid(linkValid),
  .linkIdx(linkIdx), .linkValue(linkValue)
);

// File: tb/delay_slot_pc_bench.sv
module delay_slot_pc_bench;
  localparam logic [31:0] START = 32'h0000_1000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        stepEn = 1'b0, halted = 1'b0;
  logic [5:0]  opcode = '0, funct = '0;
  logic [4:0]  rtField = '0, rdIdx = '0;
  logic [15:0] offset16 = '0;
  logic [25:0] jumpIndex = '0;
  logic [31:0] rsVal = '0, rtVal = '0;
  logic [31:0] pcOut, nextPcOut, linkValue;
  logic        linkValid;
  logic [4:0]  linkIdx;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  typedef struct {
    logic [31:0] pc;
    logic [31:0] npc;
    string       tag;
  } expItem_t;
  expItem_t sbq[$];

  logic [31:0] mPc, mNpc;

  always #4 clk = ~clk;

  delay_slot_pc #(.START_ADDR(START)) u_delay_slot_pc (
    .clk(clk), .rst_n(rst_n), .stepEn(stepEn), .halted(halted),
    .opcode(opcode), .funct(funct), .rtField(rtField), .rdIdx(rdIdx),
    .offset16(offset16), .jumpIndex(jumpIndex), .rsVal(rsVal), .rtVal(rtVal),
    .pcOut(pcOut), .nextPcOut(nextPcOut), .linkValid(linkValid),
    .linkIdx(linkIdx), .linkValue(linkValue)
  );

  task automatic check32(string tag, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // driver: drive one retiring instruction, check link outputs, push the expected pair
  task automatic drive(string tag, logic [5:0] op, logic [5:0] fn, logic [4:0] rtf,
                       logic [4:0] rd, logic [15:0] off, logic [25:0] idx,
                       logic [31:0] rs, logic [31:0] rt, logic en, logic hlt);
    bit go, tk, lk;
    logic [31:0] nNpc;
    logic [4:0]  lIdx;
    @(negedge clk);
    opcode = op; funct = fn; rtField = rtf; rdIdx = rd; offset16 = off;
    jumpIndex = idx; rsVal = rs; rtVal = rt; stepEn = en; halted = hlt;
    go = en && !hlt;
    tk = 0;
    case (op)
      6'd4: tk = (rs == rt);
      6'd5: tk = (rs != rt);
      6'd6: tk = ($signed(rs) <= 0);
      6'd7: tk = ($signed(rs) > 0);
      6'd1: tk = (rtf == 5'd0) ? ($signed(rs) < 0) : (rtf == 5'd1) ? ($signed(rs) >= 0) : 1'b0;
      default: tk = 0;
    endcase
    nNpc = mNpc + 32'd4;
    if (tk) nNpc = mPc + 32'd4 + 32'($signed(off) * 4);
    if (op == 6'd2 || op == 6'd3) nNpc = (mNpc & 32'hF000_0000) | (32'(idx) * 4);
    if (op == 6'd0 && (fn == 6'd8 || fn == 6'd9)) nNpc = rs;
    lIdx = (op == 6'd3) ? 5'd31 : rd;
    lk = go && ((op == 6'd3) || (op == 6'd0 && fn == 6'd9 && rd != 0));
    #1;
    check32(tag, "linkValid", 32'(linkValid), 32'(lk));
    if (lk) begin
      check32("R10", "linkIdx", 32'(linkIdx), 32'(lIdx));
      check32("R10", "linkValue", linkValue, mPc + 32'd8);
    end
    if (go) begin
      mPc  = mNpc;
      mNpc = nNpc;
    end
    sbq.push_back('{mPc, mNpc, tag});
  endtask

  // monitor: compare the registered pair after each edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sbq.size() > 0) begin
        expItem_t it;
        it = sbq.pop_front();
        check32(it.tag, "pcOut", pcOut, it.pc);
        check32(it.tag, "nextPcOut", nextPcOut, it.npc);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    mPc  = START;
    mNpc = START + 32'd4;
    repeat (3) @(negedge clk);
    #1;
    check32("R1", "pcOut reset", pcOut, START);
    check32("R1", "nextPcOut reset", nextPcOut, START + 32'd4);
    rst_n = 1'b1;
    // R2: plain arithmetic ops
    drive("R2", 6'd0, 6'h20, 0, 3, 0, 0, 1, 2, 1, 0);
    drive("R2", 6'd9, 6'h00, 0, 0, 16'h0010, 0, 1, 2, 1, 0);
    // R3: frozen cycles, including a linking jump while halted
    drive("R3", 6'd3, 0, 0, 0, 0, 26'h123, 0, 0, 1, 1);
    drive("R3", 6'd0, 6'd9, 0, 7, 0, 0, 32'h40, 0, 0, 0);
    // R4
    drive("R4", 6'd4, 0, 0, 0, 16'h0008, 0, 32'd5, 32'd5, 1, 0);
    drive("R4", 6'd4, 0, 0, 0, 16'h0008, 0, 32'd5, 32'd6, 1, 0);
    drive("R4", 6'd5, 0, 0, 0, 16'hFFF0, 0, 32'd5, 32'd6, 1, 0);
    drive("R4", 6'd5, 0, 0, 0, 16'hFFF0, 0, 32'd9, 32'd9, 1, 0);
    // R5
    drive("R5", 6'd6, 0, 0, 0, 16'h0004, 0, 32'd0, 0, 1, 0);
    drive("R5", 6'd6, 0, 0, 0, 16'h0004, 0, 32'hFFFF_FFFF, 0, 1, 0);
    drive("R5", 6'd6, 0, 0, 0, 16'h0004, 0, 32'd1, 0, 1, 0);
    drive("R5", 6'd7, 0, 0, 0, 16'h0002, 0, 32'd0, 0, 1, 0);
    drive("R5", 6'd7, 0, 0, 0, 16'h0002, 0, 32'h7FFF_FFFF, 0, 1, 0);
    drive("R5", 6'd7, 0, 0, 0, 16'h0002, 0, 32'h8000_0000, 0, 1, 0);
    // R6
    drive("R6", 6'd1, 0, 5'd0, 0, 16'h0003, 0, 32'h8000_0000, 0, 1, 0);
    drive("R6", 6'd1, 0, 5'd0, 0, 16'h0003, 0, 32'd0, 0, 1, 0);
    drive("R6", 6'd1, 0, 5'd1, 0, 16'hFFFE, 0, 32'd0, 0, 1, 0);
    drive("R6", 6'd1, 0, 5'd1, 0, 16'hFFFE, 0, 32'hFFFF_FFF0, 0, 1, 0);
    drive("R6", 6'd1, 0, 5'd2, 0, 16'h0040, 0, 32'hFFFF_FFF0, 0, 1, 0);
    drive("R6", 6'd1, 0, 5'd17, 0, 16'h0040, 0, 32'd4, 0, 1, 0);
    // R7: backward taken branch followed by its delay slot
    drive("R7", 6'd4, 0, 0, 0, 16'h8000, 0, 32'd1, 32'd1, 1, 0);
    drive("R7", 6'd0, 6'h21, 0, 2, 0, 0, 0, 0, 1, 0);
    // R9: register jump to a high region, rd 0 means no link
    drive("R9", 6'd0, 6'd8, 0, 4, 0, 0, 32'h7000_0100, 0, 1, 0);
    drive("R9", 6'd0, 6'h20, 0, 1, 0, 0, 0, 0, 1, 0);
    // R8: direct jumps keep the delay slot's top bits
    drive("R8", 6'd2, 0, 0, 0, 0, 26'h3FF_FFFF, 0, 0, 1, 0);
    drive("R8", 6'd0, 6'h20, 0, 1, 0, 0, 0, 0, 1, 0);
    drive("R10", 6'd3, 0, 0, 0, 0, 26'h000_0040, 0, 0, 1, 0);
    drive("R10", 6'd0, 6'h20, 0, 1, 0, 0, 0, 0, 1, 0);
    // R10: jalr with rd 5, then with rd 0
    drive("R10", 6'd0, 6'd9, 0, 5'd5, 0, 0, 32'h0000_2000, 0, 1, 0);
    drive("R10", 6'd0, 6'h20, 0, 1, 0, 0, 0, 0, 1, 0);
    drive("R10", 6'd0, 6'd9, 0, 5'd0, 0, 0, 32'h0000_3000, 0, 1, 0);
    drive("R2", 6'd0, 6'h20, 0, 1, 0, 0, 0, 0, 1, 0);
    @(negedge clk);
    stepEn = 1'b0;
    repeat (3) @(negedge clk);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule